// File: doc/BRIEF.md
# SPI Receive Status and Overrun Flags

This block holds the receive-side status of a CPU-mapped SPI peripheral. The serial shift engine hands it a one-cycle strobe each time a byte finishes, together with that byte. The block keeps a one-byte receive holding register, a receive-full flag and an overrun flag. It watches the CPU's read strobes for the status and data registers, so that each flag is cleared only by an ordered pair of accesses: first a status read that finds the flag set, then a data read. An overrun keeps the byte already held and throws the new one away. While overrun is pending, further bytes cannot raise receive-full again, so software has to service the error before it sees more data.

Each flag is tracked by its own three-state machine. `FL_CLEAR` goes to `FL_SET` on a set event. `FL_SET` goes to `FL_ARMED` on a status read. `FL_ARMED` goes to `FL_CLEAR` on a data read, or stays in `FL_SET` if a set event arrives in that same cycle. A status write loads two interrupt enables. A mode-fault level, detected elsewhere, enters only the shared interrupt output.

Top module: `spi_rx_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the holding register to zero, clears both flags and both enables, and leaves `irq` low.
- R2: A strobe on `rx_done` while receive-full and overrun are both clear sets `rx_full` and loads `rx_byte` into `rx_data`, both visible after that edge.
- R3: `rx_full` clears at the edge of a data read, provided an earlier status read saw `rx_full` set and no data read came in between.
- R4: None of these clears a flag: a data read with no status read before it, a data read after a status read that saw the flag clear, or a status write.
- R5: A strobe while `rx_full` is set and overrun is clear sets `overrun`, discards the new byte, and leaves `rx_data` unchanged.
- R6: `overrun` clears at the edge of a data read that follows a status read which saw `overrun` set. That read still shows the older held byte.
- R7: While `overrun` is set and is not being cleared in that cycle, a strobe does not set `rx_full` and does not change `rx_data`.
- R8: If a strobe arrives in the same cycle as a data read that clears `rx_full`, the new byte is loaded and `rx_full` stays set.
- R9: `irq` is high exactly when (`rx_full` and `rx_ie`) or (`err_ie` and (`overrun` or `mode_fault`)). `overrun` and `mode_fault` have no separate enables.
- R10: A status write loads `ctl_wdata[0]` into `rx_ie` and `ctl_wdata[1]` into `err_ie`, both visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_done | input | 1 | One-cycle byte-complete strobe from the shift engine |
| rx_byte | input | DW | Byte that has just completed |
| mode_fault | input | 1 | Mode-fault flag level from elsewhere in the peripheral |
| rd_stat | input | 1 | CPU read strobe, status register |
| rd_data | input | 1 | CPU read strobe, data register |
| wr_stat | input | 1 | CPU write strobe, status register |
| ctl_wdata | input | 2 | Write data: bit 0 receive enable, bit 1 error enable |
| rx_data | output | DW | Receive holding register |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| rx_ie | output | 1 | Receive interrupt enable |
| err_ie | output | 1 | Error interrupt enable |
| irq | output | 1 | Combined receive/error interrupt request |

## Verification
The hardest state to reach is the one where receive-full has already been cleared but overrun is still pending. Bytes arriving then must be dropped without raising receive-full. To get there, the bench performs a status read while only receive-full is set, lets a second byte arrive to raise overrun, and then does the data read. That read clears receive-full alone, because the status read never saw overrun. The bench then sends a third byte and checks that the flags and the held byte do not move. The same-cycle collision of a clearing data read with a new strobe is driven as a single cycle in which both inputs are asserted.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_t;

    typedef struct packed {
        logic err_ie;
        logic rx_ie;
    } irq_en_t;
endpackage

// File: rtl/spi_rx_flag_fsm.sv
module spi_rx_flag_fsm
    import spi_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rd_stat,
    input  logic rd_data,
    output logic flag,
    output logic clr_now
);
    flag_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= FL_CLEAR;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_CLEAR: if (set_evt) st_d = FL_SET;
            FL_SET:   if (rd_stat) st_d = FL_ARMED;
            FL_ARMED: if (rd_data) st_d = set_evt ? FL_SET : FL_CLEAR;
            default:  st_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        flag    = 1'b0;
        clr_now = 1'b0;
        unique case (st_q)
            FL_CLEAR: flag = 1'b0;
            FL_SET:   flag = 1'b1;
            FL_ARMED: begin
                flag    = 1'b1;
                clr_now = rd_data;
            end
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_rx_data_reg.sv
module spi_rx_data_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/spi_rx_irq_merge.sv
module spi_rx_irq_merge
    import spi_rx_pkg::*;
(
    input  irq_en_t en,
    input  logic    full,
    input  logic    ovr,
    input  logic    mfault,
    output logic    irq
);
    logic rx_req, err_req;

    always_comb begin
        rx_req  = full & en.rx_ie;
        err_req = en.err_ie & (ovr | mfault);
        irq     = rx_req | err_req;
    end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
    import spi_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          mode_fault,
    input  logic          rd_stat,
    input  logic          rd_data,
    input  logic          wr_stat,
    input  logic [1:0]    ctl_wdata,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          overrun,
    output logic          rx_ie,
    output logic          err_ie,
    output logic          irq
);
    logic    full_clr, ovr_clr;
    logic    full_eff, ovr_eff;
    logic    load_byte, ovr_set;
    irq_en_t en_q;

    // Flag values as they stand once this cycle's clearing read is applied.
    always_comb begin
        full_eff  = rx_full & ~full_clr;
        ovr_eff   = overrun & ~ovr_clr;
        load_byte = rx_done & ~ovr_eff & ~full_eff;
        ovr_set   = rx_done & ~ovr_eff & full_eff;
    end

    spi_rx_flag_fsm u_full (
        .clk     (clk),
        .rst     (rst),
        .set_evt (load_byte),
        .rd_stat (rd_stat),
        .rd_data (rd_data),
        .flag    (rx_full),
        .clr_now (full_clr)
    );

    spi_rx_flag_fsm u_ovr (
        .clk     (clk),
        .rst     (rst),
        .set_evt (ovr_set),
        .rd_stat (rd_stat),
        .rd_data (rd_data),
        .flag    (overrun),
        .clr_now (ovr_clr)
    );

    spi_rx_data_reg #(.DW(DW)) u_data (
        .clk  (clk),
        .rst  (rst),
        .load (load_byte),
        .din  (rx_byte),
        .dout (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst)          en_q <= '0;
        else if (wr_stat) en_q <= '{err_ie: ctl_wdata[1], rx_ie: ctl_wdata[0]};
    end

    assign rx_ie  = en_q.rx_ie;
    assign err_ie = en_q.err_ie;

    spi_rx_irq_merge u_irq (
        .en     (en_q),
        .full   (rx_full),
        .ovr    (overrun),
        .mfault (mode_fault),
        .irq    (irq)
    );
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_done,
    input logic [DW-1:0] rx_byte,
    input logic          rd_data,
    input logic [DW-1:0] rx_data,
    input logic          rx_full,
    input logic          overrun,
    input logic          rx_ie,
    input logic          err_ie,
    input logic          irq
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (rx_data == '0) && !rx_full && !overrun && !rx_ie && !err_ie && !irq);

    // R2
    load_byte_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done && !rx_full && !overrun |=> rx_full && (rx_data == $past(rx_byte)));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full && !rd_data |=> rx_full);

    // R5
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done && rx_full && !rd_data |=> $stable(rx_data));

    // R7
    ovr_block_chk: assert property (@(posedge clk) disable iff (rst)
        overrun && !rx_full && !rd_data |=> !rx_full && $stable(rx_data));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_ie && !err_ie |-> !irq);
endmodule

bind spi_rx_status spi_rx_status_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .rd_data (rd_data),
    .rx_data (rx_data),
    .rx_full (rx_full),
    .overrun (overrun),
    .rx_ie   (rx_ie),
    .err_ie  (err_ie),
    .irq     (irq)
);

// File: tb/tb_spi_rx_status.sv
module tb_spi_rx_status;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_done, mode_fault, rd_stat, rd_data, wr_stat;
    logic [DW-1:0] rx_byte;
    logic [1:0]    ctl_wdata;
    logic [DW-1:0] rx_data;
    logic          rx_full, overrun, rx_ie, err_ie, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_rx_status #(.DW(DW)) dut (
        .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte),
        .mode_fault(mode_fault), .rd_stat(rd_stat), .rd_data(rd_data),
        .wr_stat(wr_stat), .ctl_wdata(ctl_wdata), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun), .rx_ie(rx_ie),
        .err_ie(err_ie), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock cycle with the given strobes; outputs are valid on return.
    task automatic cyc(input logic s, input logic d, input logic done,
                       input logic [DW-1:0] b, input logic w, input logic [1:0] wd);
        rd_stat = s; rd_data = d; rx_done = done; rx_byte = b;
        wr_stat = w; ctl_wdata = wd;
        @(negedge clk);
        rd_stat = 0; rd_data = 0; rx_done = 0; wr_stat = 0;
    endtask

    task automatic byte_in(input logic [DW-1:0] b); cyc(0, 0, 1, b, 0, 2'b00); endtask
    task automatic srd();                          cyc(1, 0, 0, '0, 0, 2'b00); endtask
    task automatic drd();                          cyc(0, 1, 0, '0, 0, 2'b00); endtask
    task automatic swr(input logic [1:0] wd);      cyc(0, 0, 0, '0, 1, wd);    endtask

    task automatic t_reset();
        rst = 1; @(negedge clk); @(negedge clk); rst = 0;
        chk("R1 data", rx_data, 0);
        chk("R1 flags", {rx_full, overrun, rx_ie, err_ie, irq}, 0);
    endtask

    task automatic t_basic();
        byte_in(8'hA5);
        chk("R2 full", rx_full, 1);
        chk("R2 data", rx_data, 8'hA5);
        srd();
        chk("R3 still set after status read", rx_full, 1);
        drd();
        chk("R3 cleared", rx_full, 0);
        chk("R3 data kept", rx_data, 8'hA5);
    endtask

    task automatic t_no_clear();
        srd();                       // status read sees flag clear
        byte_in(8'h3C);
        drd();
        chk("R4 read after stale status", rx_full, 1);
        drd();
        chk("R4 data read alone", rx_full, 1);
        srd(); swr(2'b00);
        chk("R4 status write", rx_full, 1);
        drd();
        chk("R3 armed survives write", rx_full, 0);
    endtask

    task automatic t_overrun();
        byte_in(8'h11);
        srd();                       // sees full only
        byte_in(8'h22);
        chk("R5 overrun set", overrun, 1);
        chk("R5 data kept", rx_data, 8'h11);
        drd();
        chk("R3 full cleared, overrun pending", {rx_full, overrun}, 2'b01);
        byte_in(8'h33);
        chk("R7 full stays clear", rx_full, 0);
        chk("R7 data unchanged", rx_data, 8'h11);
        srd(); drd();
        chk("R6 overrun cleared", overrun, 0);
        chk("R6 older byte kept", rx_data, 8'h11);
        byte_in(8'h44);
        chk("R2 after overrun", {rx_full, rx_data}, {1'b1, 8'h44});
        srd(); drd();
    endtask

    task automatic t_same_cycle();
        byte_in(8'h55);
        srd();
        cyc(0, 1, 1, 8'h66, 0, 2'b00);
        chk("R8 full stays", rx_full, 1);
        chk("R8 new byte", rx_data, 8'h66);
        chk("R8 no overrun", overrun, 0);
        srd(); drd();
        chk("R3 clear after collision", rx_full, 0);
    endtask

    task automatic t_irq();
        swr(2'b01);
        chk("R10 enables", {err_ie, rx_ie}, 2'b01);
        chk("R9 idle", irq, 0);
        byte_in(8'h77);
        chk("R9 full irq", irq, 1);
        srd(); drd();
        mode_fault = 1;
        #0;
        chk("R9 fault masked", irq, 0);
        swr(2'b10);
        chk("R10 enables2", {err_ie, rx_ie}, 2'b10);
        chk("R9 fault irq", irq, 1);
        mode_fault = 0;
        byte_in(8'h01);
        chk("R9 full masked", irq, 0);
        byte_in(8'h02);
        chk("R9 overrun irq", irq, 1);
        swr(2'b00);
        chk("R9 all masked", irq, 0);
        chk("R4 write keeps flags", {rx_full, overrun}, 2'b11);
    endtask

    initial begin
        rst = 1; rx_done = 0; mode_fault = 0; rd_stat = 0; rd_data = 0;
        wr_stat = 0; rx_byte = '0; ctl_wdata = '0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_clear();
        t_overrun();
        t_same_cycle();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule